// File: doc/BRIEF.md
# Dual-Queue Converter Status Flag Register

This block is the 16-bit status word of a converter sequencer that runs two independent conversion queues. The sequencer reports events to it: a queue finished its last command word, a queue reached a command word marked as a pause point, and a trigger edge arrived for a queue. With each trigger edge it also supplies that queue's current state and trigger mode. The block keeps six sticky flags: completion, pause and trigger overrun, one of each per queue. It shows them on a simple read/write register bus and drives them as registered level outputs for a downstream interrupt block.

Software clears a flag with a two-step handshake. A read that returns the flag as 1 arms it, and a later write of 0 to that bit clears it. Each flag is a small state machine with three states. FL_CLEAR means the flag is 0. FL_HELD means the flag is 1 and not armed. FL_ARMED means the flag is 1 and armed by a read. The transitions are:

- set: FL_CLEAR to FL_HELD, on a set event.
- arm: FL_HELD to FL_ARMED, on a bus read without a write in the same cycle.
- clear: FL_ARMED to FL_CLEAR, on a write of 0 to the bit with no set event.
- clear-with-set: FL_ARMED to FL_HELD, on a write of 0 that coincides with a set event.

Top module: `qadc_status_reg`

## Requirements
- R1: After reset, all six flags are 0, `bus_rdata` reads 0x0000 and `flag_lvl` is 0.
- R2: A pulse on `q1_end_done` sets bit 15. A pulse on `q2_end_done` sets bit 13. Each flag is visible on the cycle after the event edge.
- R3: A pulse on `q1_pause_done` sets bit 14. A pulse on `q2_pause_done` sets bit 12.
- R4: The queue 1 overrun flag (bit 11) is set by `q1_trig` only when `q1_state` is ACTIVE (2'b01) and `q1_mode` is external edge (2'b10). It is not set in IDLE (00), SUSPENDED (10) or TRIG_PEND (11), and not in software single (00), software continuous (01) or timer (11) mode.
- R5: The queue 2 overrun flag (bit 10) is set by `q2_trig` when `q2_state` is ACTIVE, SUSPENDED or TRIG_PEND and `q2_mode` is external edge or timer. It is never set in IDLE or in either software mode.
- R6: A write of 0 to a set flag that has not been read as 1 leaves the flag set.
- R7: A read that returns a flag as 1 arms it. A following write of 0 to that bit clears it. A write of 1 has no effect and keeps the flag armed.
- R8: When a set event and a clearing write hit the same flag in one cycle, the flag stays 1 and loses its arm. A further write of 0 without a new read leaves the flag set.
- R9: A set event that arrives while a flag is armed, in a cycle without a write, does not block the clear: the next write of 0 still clears the flag.
- R10: Bits 9 to 0 always read 0, and writes to them have no effect on any flag.
- R11: `flag_lvl[5:0]` equals `bus_rdata[15:10]` on every cycle.
- R12: When a read and a write occur in the same cycle, the write acts on the arm state from before that cycle, and the read does not arm.
- R13: A read that returns a flag as 0 does not arm it. If the flag is set later, a write of 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q1_end_done | input | 1 | Queue 1 last command word converted and stored |
| q1_pause_done | input | 1 | Queue 1 pause-point word converted and stored |
| q2_end_done | input | 1 | Queue 2 last command word converted and stored |
| q2_pause_done | input | 1 | Queue 2 pause-point word converted and stored |
| q1_trig | input | 1 | Queue 1 trigger edge |
| q2_trig | input | 1 | Queue 2 trigger edge |
| q1_state | input | 2 | Queue 1 state: 0 idle, 1 active, 2 suspended, 3 trigger pending |
| q1_mode | input | 2 | Queue 1 mode: 0 sw single, 1 sw continuous, 2 external edge, 3 timer |
| q2_state | input | 2 | Queue 2 state, same encoding |
| q2_mode | input | 2 | Queue 2 mode, same encoding |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data: flags in bits 15:10, zero below |
| flag_lvl | output | 6 | Level per flag: [5] q1 done, [4] q1 pause, [3] q2 done, [2] q2 pause, [1] q1 overrun, [0] q2 overrun |

## Verification
The bench goes after collisions: a set event in the same cycle as a clearing write, and a read in the same cycle as a write. A design that let the clear win would drop an event. A design that armed on the colliding read would clear a flag software never saw. It also walks every state and mode pairing for both overrun flags. Swapping the two queues' qualifying rules would set queue 1's overrun while suspended, or miss queue 2's overrun in timer mode. Clears without a prior read, and reads that returned 0, are checked too. A design that ignored the arm would clear flags on blind writes.

// File: rtl/qadc_stat_pkg.sv
package qadc_stat_pkg;
    typedef enum logic [1:0] {
        QS_IDLE      = 2'd0,
        QS_ACTIVE    = 2'd1,
        QS_SUSPENDED = 2'd2,
        QS_TRIG_PEND = 2'd3
    } qstate_e;

    typedef enum logic [1:0] {
        TM_SW_SINGLE = 2'd0,
        TM_SW_CONT   = 2'd1,
        TM_EXT_EDGE  = 2'd2,
        TM_TIMER     = 2'd3
    } tmode_e;

    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_HELD  = 2'd1,
        FL_ARMED = 2'd2
    } flag_st_e;

    localparam int unsigned REG_W     = 16;
    localparam int unsigned NUM_FLAGS = 6;
    localparam int unsigned FLAG_LSB  = REG_W - NUM_FLAGS;
endpackage

// File: rtl/ovr_qual.sv
module ovr_qual
    import qadc_stat_pkg::*;
#(
    parameter int QUEUE_SEL = 1
) (
    input  logic       trig_i,
    input  logic [1:0] state_i,
    input  logic [1:0] mode_i,
    output logic       ovr_o
);
    qstate_e st;
    tmode_e  md;
    assign st = qstate_e'(state_i);
    assign md = tmode_e'(mode_i);

    generate
        if (QUEUE_SEL == 1) begin : g_q1_rule
            // queue 1: active state, external edge mode only
            assign ovr_o = trig_i && (st == QS_ACTIVE) && (md == TM_EXT_EDGE);
        end else begin : g_q2_rule
            // queue 2: any non-idle state, external edge or timer mode
            assign ovr_o = trig_i && (st != QS_IDLE)
                           && ((md == TM_EXT_EDGE) || (md == TM_TIMER));
        end
    endgenerate
endmodule

// File: rtl/flag_cell.sv
module flag_cell
    import qadc_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic lvl_o
);
    flag_st_e st_q, st_nxt;
    logic     clr_req, arm_req;

    assign clr_req = wr_i && !wbit_i;
    assign arm_req = rd_i && !wr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FL_CLEAR;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            FL_CLEAR: if (set_i)   st_nxt = FL_HELD;
            FL_HELD:  if (arm_req) st_nxt = FL_ARMED;
            FL_ARMED: if (clr_req) st_nxt = set_i ? FL_HELD : FL_CLEAR;
            default:               st_nxt = FL_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_o <= 1'b0;
        else        lvl_o <= (st_nxt != FL_CLEAR);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> lvl_o); // R8
    AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lvl_o) |-> $past(st_q == FL_ARMED && wr_i && !wbit_i)); // R6
    AST_W1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o && wr_i && wbit_i) |=> lvl_o); // R7
endmodule

// File: rtl/qadc_status_reg.sv
module qadc_status_reg
    import qadc_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        q1_end_done,
    input  logic        q1_pause_done,
    input  logic        q2_end_done,
    input  logic        q2_pause_done,
    input  logic        q1_trig,
    input  logic        q2_trig,
    input  logic [1:0]  q1_state,
    input  logic [1:0]  q1_mode,
    input  logic [1:0]  q2_state,
    input  logic [1:0]  q2_mode,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic [5:0]  flag_lvl
);
    logic [NUM_FLAGS-1:0] set_vec;
    logic                 ovr1, ovr2;
    logic                 unused_wlow;

    ovr_qual #(.QUEUE_SEL(1)) u_qual1 (
        .trig_i(q1_trig), .state_i(q1_state), .mode_i(q1_mode), .ovr_o(ovr1));
    ovr_qual #(.QUEUE_SEL(2)) u_qual2 (
        .trig_i(q2_trig), .state_i(q2_state), .mode_i(q2_mode), .ovr_o(ovr2));

    // bit order within the flag field is fixed by software decoding
    assign set_vec = {q1_end_done, q1_pause_done, q2_end_done,
                      q2_pause_done, ovr1, ovr2};

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_vec[i]),
                .rd_i   (bus_rd),
                .wr_i   (bus_wr),
                .wbit_i (bus_wdata[FLAG_LSB+i]),
                .lvl_o  (flag_lvl[i])
            );
        end
    endgenerate

    assign bus_rdata   = {flag_lvl, {FLAG_LSB{1'b0}}};
    assign unused_wlow = ^bus_wdata[FLAG_LSB-1:0];

    AST_Q1_OVR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_lvl[1]) |-> $past(q1_trig && q1_state == 2'd1 && q1_mode == 2'd2)); // R4
    AST_Q2_OVR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_lvl[0]) |-> $past(q2_trig && q2_state != 2'd0 && q2_mode[1])); // R5
    AST_Q1_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_lvl[5]) |-> $past(q1_end_done)); // R2
endmodule

// File: tb/test_qadc_status_reg.sv
`timescale 1ns/1ps
module test_qadc_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        q1_end_done = 0, q1_pause_done = 0, q2_end_done = 0, q2_pause_done = 0;
    logic        q1_trig = 0, q2_trig = 0;
    logic [1:0]  q1_state = 0, q1_mode = 0, q2_state = 0, q2_mode = 0;
    logic        bus_rd = 0, bus_wr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic [5:0]  flag_lvl;

    integer n_vec = 0;
    integer n_bad = 0;
    string  cur_req = "R1";
    bit     m_flag [6];
    bit     m_arm  [6];

    always #2.5 clk = ~clk;

    qadc_status_reg i_qadc_status_reg (
        .clk(clk), .rst_n(rst_n),
        .q1_end_done(q1_end_done), .q1_pause_done(q1_pause_done),
        .q2_end_done(q2_end_done), .q2_pause_done(q2_pause_done),
        .q1_trig(q1_trig), .q2_trig(q2_trig),
        .q1_state(q1_state), .q1_mode(q1_mode),
        .q2_state(q2_state), .q2_mode(q2_mode),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .flag_lvl(flag_lvl));

    function automatic logic [15:0] model_word();
        logic [15:0] w = 16'h0000;
        for (int i = 0; i < 6; i++) w[10+i] = m_flag[i];
        return w;
    endfunction

    task automatic model_edge();
        bit ev [6];
        ev[5] = q1_end_done;
        ev[4] = q1_pause_done;
        ev[3] = q2_end_done;
        ev[2] = q2_pause_done;
        ev[1] = q1_trig && (q1_state == 2'd1) && (q1_mode == 2'd2);
        ev[0] = q2_trig && (q2_state != 2'd0) && (q2_mode >= 2'd2);
        for (int i = 0; i < 6; i++) begin
            bit clr, arm;
            clr = bus_wr && !bus_wdata[10+i] && m_arm[i];
            arm = bus_rd && !bus_wr && m_flag[i];
            m_arm[i]  = (m_arm[i] && !clr) || arm;
            m_flag[i] = ev[i] || (m_flag[i] && !clr);
        end
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: inputs already driven at negedge
    task automatic cyc();
        @(posedge clk);
        model_edge();
        #1;
        chk({cur_req, " model"}, bus_rdata, model_word());
        chk("R11 level", {10'd0, flag_lvl}, {10'd0, bus_rdata[15:10]});
        @(negedge clk);
        q1_end_done = 0; q1_pause_done = 0; q2_end_done = 0; q2_pause_done = 0;
        q1_trig = 0; q2_trig = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 16'h0000;
    endtask

    task automatic do_read();
        bus_rd = 1; cyc();
    endtask

    task automatic do_write(input logic [15:0] d);
        bus_wr = 1; bus_wdata = d; cyc();
    endtask

    task automatic trig1(input logic [1:0] s, input logic [1:0] m, input logic [15:0] exp, input string tag);
        q1_state = s; q1_mode = m; q1_trig = 1; cyc();
        chk(tag, bus_rdata, exp);
    endtask

    task automatic trig2(input logic [1:0] s, input logic [1:0] m, input logic [15:0] exp, input string tag);
        q2_state = s; q2_mode = m; q2_trig = 1; cyc();
        chk(tag, bus_rdata, exp);
    endtask

    task automatic clear_all();
        do_read(); do_write(16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) begin m_flag[i] = 0; m_arm[i] = 0; end
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset rdata", bus_rdata, 16'h0000);
        chk("R1 reset lvl", {10'd0, flag_lvl}, 16'h0000);
        rst_n = 1;
        @(negedge clk);

        cur_req = "R2";
        q1_end_done = 1; cyc(); chk("R2 q1 done bit15", bus_rdata, 16'h8000);
        q2_end_done = 1; cyc(); chk("R2 q2 done bit13", bus_rdata, 16'hA000);

        cur_req = "R6";
        do_write(16'h0000); chk("R6 blind write0", bus_rdata, 16'hA000);

        cur_req = "R7";
        do_read();
        do_write(16'hFFFF); chk("R7 write1 no effect", bus_rdata, 16'hA000);
        do_write(16'h0000); chk("R7 armed clear", bus_rdata, 16'h0000);

        cur_req = "R3";
        q1_pause_done = 1; cyc();
        q2_pause_done = 1; cyc(); chk("R3 pause bits 14 12", bus_rdata, 16'h5000);
        chk("R11 lvl pause", {10'd0, flag_lvl}, 16'h0014);

        cur_req = "R10";
        do_write(16'h03FF); chk("R10 low write", bus_rdata, 16'h5000);
        do_read();
        do_write(16'hF3FF); chk("R10 low bits ignored armed", bus_rdata, 16'h5000);
        do_write(16'h0000); chk("R10 then clear", bus_rdata, 16'h0000);

        cur_req = "R4";
        trig1(2'd0, 2'd2, 16'h0000, "R4 idle ext");
        trig1(2'd1, 2'd0, 16'h0000, "R4 active sw single");
        trig1(2'd1, 2'd1, 16'h0000, "R4 active sw cont");
        trig1(2'd1, 2'd3, 16'h0000, "R4 active timer");
        trig1(2'd2, 2'd2, 16'h0000, "R4 suspended ext");
        trig1(2'd3, 2'd2, 16'h0000, "R4 trig pend ext");
        trig1(2'd1, 2'd2, 16'h0800, "R4 active ext");
        clear_all();

        cur_req = "R5";
        trig2(2'd0, 2'd2, 16'h0000, "R5 idle ext");
        trig2(2'd1, 2'd0, 16'h0000, "R5 active sw single");
        trig2(2'd2, 2'd1, 16'h0000, "R5 susp sw cont");
        trig2(2'd1, 2'd2, 16'h0400, "R5 active ext");
        clear_all();
        trig2(2'd2, 2'd3, 16'h0400, "R5 suspended timer");
        clear_all();
        trig2(2'd3, 2'd2, 16'h0400, "R5 trig pend ext");
        clear_all();
        chk("R5 cleared", bus_rdata, 16'h0000);

        cur_req = "R8";
        q1_end_done = 1; cyc();
        do_read();
        q1_end_done = 1; bus_wr = 1; bus_wdata = 16'h0000; cyc();
        chk("R8 set beats clear", bus_rdata, 16'h8000);
        do_write(16'h0000); chk("R8 arm lost", bus_rdata, 16'h8000);
        clear_all(); chk("R8 re-read clears", bus_rdata, 16'h0000);

        cur_req = "R9";
        q2_end_done = 1; cyc();
        do_read();
        q2_end_done = 1; cyc();
        do_write(16'h0000); chk("R9 clear after re-set", bus_rdata, 16'h0000);

        cur_req = "R12";
        q1_pause_done = 1; cyc();
        bus_rd = 1; bus_wr = 1; bus_wdata = 16'h0000; cyc();
        chk("R12 rd+wr no prior arm", bus_rdata, 16'h4000);
        do_write(16'h0000); chk("R12 read did not arm", bus_rdata, 16'h4000);
        do_read();
        bus_rd = 1; bus_wr = 1; bus_wdata = 16'h0000; cyc();
        chk("R12 rd+wr uses prior arm", bus_rdata, 16'h0000);

        cur_req = "R13";
        do_read();
        q2_pause_done = 1; cyc();
        do_write(16'h0000); chk("R13 read of 0 no arm", bus_rdata, 16'h1000);
        clear_all(); chk("R13 cleared", bus_rdata, 16'h0000);

        cur_req = "R11";
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            q1_end_done   = (r[2:0] == 3'd0);
            q1_pause_done = (r[5:3] == 3'd0);
            q2_end_done   = (r[8:6] == 3'd0);
            q2_pause_done = (r[11:9] == 3'd0);
            q1_trig  = r[12]; q2_trig = r[13];
            q1_state = r[15:14]; q1_mode = r[17:16];
            q2_state = r[19:18]; q2_mode = r[21:20];
            bus_rd   = r[22] | r[23];
            bus_wr   = r[24] & r[25];
            bus_wdata = {r[31:26], r[9:0]};
            cyc();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule